// File: doc/BRIEF.md
# Context-Tagged Virtual Write-Through Data Cache

A direct-mapped data cache that is both indexed and tagged by virtual address, placed between a processor load/store port and a single-beat main-memory port. Each line holds sixteen bytes as four 32-bit words. Its tag entry records the process context that filled it, copies of the write and supervisor permission flags supplied with the access, a valid flag and the upper address bits. A lookup hits only when the entry is valid, the address bits match and the stored context equals the context currently presented.

Every store goes out to memory. A store that hits also merges its enabled bytes into the cached line. A store that misses invalidates the line at its index rather than allocating one. A load that misses replaces the line with a four-beat refill and returns the requested word when the refill finishes. A separate control port reads and writes raw tag words so that software can clear all tags before the enable input is raised. While the enable is low, every access bypasses the cache as a single memory beat and the tags are left alone.

Top module: `vwt_cache`

## Requirements
- R1: An enabled load hits only when the entry at its index is valid, its tag field equals address bits [29:16] and its context field equals `cur_ctx`; a hit finishes with no memory beat and returns the cached word.
- R2: An enabled load miss performs exactly four read beats at addresses line base, +4, +8, +12 and then writes the tag word {context, pte_wr, pte_sup, valid=1, address bits [29:16]}.
- R3: Every store, hit or miss, enabled or not, issues exactly one memory write beat to the word-aligned address with the store's data and byte enables.
- R4: A store hit updates only the bytes of the addressed cached word selected by `cpu_be`; a later load hit returns the merged word without a memory beat.
- R5: A store miss clears the valid flag (bit 19) of the tag at that index and does not allocate, so the next load to that address misses.
- R6: With `cache_en` low, each load and each store is one memory beat, and no tag word changes.
- R7: Tag words written through the control port read back with bits [31:25], [18:16] and [1:0] forced to zero; the fields are context [24:22], write flag [21], supervisor flag [20], valid [19] and tag [15:2].
- R8: After reset `cpu_done`, `ctl_done` and `mem_req` are low, and the two done outputs are never high together.
- R9: A load returns the word selected by address bits [3:2] of its line, whether it hits, refills or bypasses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cache_en | input | 1 | Cache enable; low means every access bypasses |
| cur_ctx | input | 3 | Current context identifier |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Virtual byte address |
| cpu_be | input | 4 | Store byte enables |
| cpu_wdata | input | 32 | Store data |
| pte_wr | input | 1 | Write permission copied into a refilled tag |
| pte_sup | input | 1 | Supervisor flag copied into a refilled tag |
| cpu_rdata | output | 32 | Load data, valid with `cpu_done` |
| cpu_done | output | 1 | One-cycle completion pulse |
| ctl_req | input | 1 | Control-port request, held until `ctl_done` |
| ctl_we | input | 1 | 1 = write tag word, 0 = read |
| ctl_idx | input | 12 | Tag index |
| ctl_wdata | input | 32 | Tag word to write |
| ctl_rdata | output | 32 | Tag word read, valid with `ctl_done` |
| ctl_done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory beat request, held until `mem_ack` |
| mem_we | output | 1 | 1 = write beat |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_be | output | 4 | Write byte enables |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Beat completion |

## Verification
The hardest state to reach is a line that is valid with a matching address tag but was filled under another context, since a hit then has to be refused on the context field alone. The stimulus draws addresses from a small pool of indices and tags and alternates between two contexts, so the same line is refilled and probed under both. The same pool makes store misses land on resident lines, and the next load then shows the line was invalidated, while occasional control-port reads compare raw tag words with a bench-side tag model.

// File: rtl/vwt_pkg.sv
package vwt_pkg;
  localparam int TID_W = 14;
  localparam int CTX_W = 3;
  localparam logic [31:0] TAG_KEEP = 32'h01F8_FFFC;

  typedef struct packed {
    logic [6:0]       pad_hi;
    logic [CTX_W-1:0] ctx;
    logic             wr;
    logic             sup;
    logic             vld;
    logic [2:0]       pad_mid;
    logic [TID_W-1:0] tid;
    logic [1:0]       pad_lo;
  } tag_word_t;

  typedef enum logic [2:0] {
    S_IDLE, S_LOOK, S_FILL, S_XFER, S_CTLR, S_DONE
  } vwt_state_t;

  function automatic tag_word_t make_tag(input logic [CTX_W-1:0] ctx,
                                         input logic wr, input logic sup,
                                         input logic [TID_W-1:0] tid);
    tag_word_t t;
    t = '0;
    t.ctx = ctx;
    t.wr  = wr;
    t.sup = sup;
    t.vld = 1'b1;
    t.tid = tid;
    return t;
  endfunction
endpackage

// File: rtl/vwt_tag_store.sv
module vwt_tag_store
  import vwt_pkg::*;
#(
  parameter int IDX_W = 12
) (
  input  logic             clk,
  input  logic             en,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [31:0] tags [DEPTH];

  // single-port, read-before-write; pad bits never stored
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) tags[idx] <= wdata & TAG_KEEP;
      rdata <= tags[idx];
    end
  end
endmodule

// File: rtl/vwt_data_store.sv
module vwt_data_store #(
  parameter int IDX_W      = 12,
  parameter int LINE_WORDS = 4
) (
  input  logic                       clk,
  input  logic                       rd_en,
  input  logic [IDX_W-1:0]           idx,
  input  logic [LINE_WORDS-1:0]      we,
  input  logic [3:0]                 be,
  input  logic [31:0]                wdata,
  output logic [LINE_WORDS*32-1:0]   rdata
);
  localparam int DEPTH = 1 << IDX_W;

  for (genvar w = 0; w < LINE_WORDS; w++) begin : g_bank
    logic [31:0] bank [DEPTH];
    logic [31:0] q;
    always_ff @(posedge clk) begin
      if (we[w]) begin
        for (int b = 0; b < 4; b++) begin
          if (be[b]) bank[idx][8*b +: 8] <= wdata[8*b +: 8];
        end
      end
      if (rd_en) q <= bank[idx];
    end
    assign rdata[32*w +: 32] = q;
  end
endmodule

// File: rtl/vwt_hit_check.sv
module vwt_hit_check
  import vwt_pkg::*;
(
  input  tag_word_t        entry,
  input  logic [TID_W-1:0] tid,
  input  logic [CTX_W-1:0] ctx,
  output logic             hit
);
  logic unused_fields;
  assign unused_fields = ^{entry.pad_hi, entry.wr, entry.sup, entry.pad_mid, entry.pad_lo};

  assign hit = entry.vld && (entry.tid == tid) && (entry.ctx == ctx);
endmodule

// File: rtl/vwt_cache.sv
module vwt_cache
  import vwt_pkg::*;
#(
  parameter int IDX_W      = 12,
  parameter int LINE_WORDS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cache_en,
  input  logic [2:0]       cur_ctx,
  input  logic             cpu_req,
  input  logic             cpu_we,
  input  logic [31:0]      cpu_addr,
  input  logic [3:0]       cpu_be,
  input  logic [31:0]      cpu_wdata,
  input  logic             pte_wr,
  input  logic             pte_sup,
  output logic [31:0]      cpu_rdata,
  output logic             cpu_done,
  input  logic             ctl_req,
  input  logic             ctl_we,
  input  logic [IDX_W-1:0] ctl_idx,
  input  logic [31:0]      ctl_wdata,
  output logic [31:0]      ctl_rdata,
  output logic             ctl_done,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [3:0]       mem_be,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  input  logic             mem_ack
);
  localparam int WSEL_W    = $clog2(LINE_WORDS);
  localparam int OFF_W     = WSEL_W + 2;
  localparam int TID_LSB   = OFF_W + IDX_W;
  localparam logic [WSEL_W-1:0] LAST_BEAT = WSEL_W'(LINE_WORDS - 1);

  vwt_state_t state;

  // captured request
  logic [31:0]      op_addr;
  logic             op_we;
  logic [3:0]       op_be;
  logic [31:0]      op_wdata;
  logic [CTX_W-1:0] op_ctx;
  logic             op_wr, op_sup;
  logic [WSEL_W-1:0] beat;

  logic [IDX_W-1:0]  op_idx, cpu_idx;
  logic [TID_W-1:0]  op_tid;
  logic [WSEL_W-1:0] op_wsel;
  assign op_idx  = op_addr[OFF_W +: IDX_W];
  assign cpu_idx = cpu_addr[OFF_W +: IDX_W];
  assign op_tid  = op_addr[TID_LSB +: TID_W];
  assign op_wsel = op_addr[2 +: WSEL_W];

  logic unused_addr;
  assign unused_addr = ^{op_addr[1:0], cpu_addr[31:OFF_W+IDX_W], cpu_addr[OFF_W-1:0]};

  // storage control
  logic             tag_en, tag_we;
  logic [IDX_W-1:0] tag_idx;
  tag_word_t        tag_wd, tag_q;
  logic [31:0]      tag_raw;
  logic                     dat_rd;
  logic [LINE_WORDS-1:0]    dat_we;
  logic [3:0]               dat_be;
  logic [31:0]              dat_wd;
  logic [IDX_W-1:0]         dat_idx;
  logic [LINE_WORDS*32-1:0] dat_q;
  logic                     hit;

  assign tag_q = tag_word_t'(tag_raw);

  vwt_tag_store #(.IDX_W(IDX_W)) u_tags (
    .clk(clk), .en(tag_en), .we(tag_we), .idx(tag_idx),
    .wdata(tag_wd), .rdata(tag_raw)
  );

  vwt_data_store #(.IDX_W(IDX_W), .LINE_WORDS(LINE_WORDS)) u_data (
    .clk(clk), .rd_en(dat_rd), .idx(dat_idx), .we(dat_we), .be(dat_be),
    .wdata(dat_wd), .rdata(dat_q)
  );

  vwt_hit_check u_hit (
    .entry(tag_q), .tid(op_tid), .ctx(op_ctx), .hit(hit)
  );

  always_comb begin
    tag_en  = 1'b0;
    tag_we  = 1'b0;
    tag_idx = op_idx;
    tag_wd  = '0;
    dat_rd  = 1'b0;
    dat_we  = '0;
    dat_be  = op_be;
    dat_wd  = op_wdata;
    dat_idx = op_idx;
    case (state)
      S_IDLE: begin
        if (ctl_req) begin
          tag_en  = 1'b1;
          tag_we  = ctl_we;
          tag_idx = ctl_idx;
          tag_wd  = tag_word_t'(ctl_wdata);
        end else if (cpu_req && cache_en) begin
          tag_en  = 1'b1;
          tag_idx = cpu_idx;
          dat_rd  = 1'b1;
          dat_idx = cpu_idx;
        end
      end
      S_LOOK: begin
        if (op_we) begin
          if (hit) begin
            dat_we[op_wsel] = 1'b1;
          end else begin
            tag_en     = 1'b1;
            tag_we     = 1'b1;
            tag_wd     = tag_q;
            tag_wd.vld = 1'b0;
          end
        end
      end
      S_FILL: begin
        if (mem_ack) begin
          dat_we[beat] = 1'b1;
          dat_be       = 4'hF;
          dat_wd       = mem_rdata;
          if (beat == LAST_BEAT) begin
            tag_en = 1'b1;
            tag_we = 1'b1;
            tag_wd = make_tag(op_ctx, op_wr, op_sup, op_tid);
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      op_addr   <= '0;
      op_we     <= 1'b0;
      op_be     <= '0;
      op_wdata  <= '0;
      op_ctx    <= '0;
      op_wr     <= 1'b0;
      op_sup    <= 1'b0;
      beat      <= '0;
      cpu_rdata <= '0;
      cpu_done  <= 1'b0;
      ctl_rdata <= '0;
      ctl_done  <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_be    <= '0;
      mem_wdata <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (ctl_req) begin
            if (ctl_we) begin
              ctl_done <= 1'b1;
              state    <= S_DONE;
            end else begin
              state <= S_CTLR;
            end
          end else if (cpu_req) begin
            op_addr  <= cpu_addr;
            op_we    <= cpu_we;
            op_be    <= cpu_be;
            op_wdata <= cpu_wdata;
            op_ctx   <= cur_ctx;
            op_wr    <= pte_wr;
            op_sup   <= pte_sup;
            if (cache_en) begin
              state <= S_LOOK;
            end else begin
              mem_req   <= 1'b1;
              mem_we    <= cpu_we;
              mem_addr  <= {cpu_addr[31:2], 2'b00};
              mem_be    <= cpu_be;
              mem_wdata <= cpu_wdata;
              state     <= S_XFER;
            end
          end
        end
        S_LOOK: begin
          if (op_we) begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= {op_addr[31:2], 2'b00};
            mem_be    <= op_be;
            mem_wdata <= op_wdata;
            state     <= S_XFER;
          end else if (hit) begin
            cpu_rdata <= dat_q[32*op_wsel +: 32];
            cpu_done  <= 1'b1;
            state     <= S_DONE;
          end else begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_be   <= 4'hF;
            mem_addr <= {op_addr[31:OFF_W], OFF_W'(0)};
            beat     <= '0;
            state    <= S_FILL;
          end
        end
        S_FILL: begin
          if (mem_ack) begin
            if (beat == op_wsel) cpu_rdata <= mem_rdata;
            if (beat == LAST_BEAT) begin
              mem_req  <= 1'b0;
              cpu_done <= 1'b1;
              state    <= S_DONE;
            end else begin
              beat     <= beat + 1'b1;
              mem_addr <= mem_addr + 32'd4;
            end
          end
        end
        S_XFER: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            if (!mem_we) cpu_rdata <= mem_rdata;
            cpu_done <= 1'b1;
            state    <= S_DONE;
          end
        end
        S_CTLR: begin
          ctl_rdata <= tag_raw;
          ctl_done  <= 1'b1;
          state     <= S_DONE;
        end
        default: begin
          cpu_done <= 1'b0;
          ctl_done <= 1'b0;
          state    <= S_IDLE;
        end
      endcase
    end
  end

  // ---------------- assertions ----------------
  logic [WSEL_W:0] fill_acks;
  always_ff @(posedge clk) begin
    if (rst) fill_acks <= '0;
    else if (state == S_LOOK) fill_acks <= '0;
    else if (state == S_FILL && mem_ack) fill_acks <= fill_acks + 1'b1;
  end

  assert_load_hit_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    (state == S_LOOK && !op_we && hit) |=> (!mem_req && cpu_done));

  assert_fill_four_beats_R2: assert property (@(posedge clk) disable iff (rst)
    (state == S_DONE && $past(state) == S_FILL) |-> (fill_acks == (WSEL_W+1)'(LINE_WORDS)));

  assert_store_forward_R3: assert property (@(posedge clk) disable iff (rst)
    (state == S_LOOK && op_we) |=> (mem_req && mem_we && mem_be == $past(op_be)));

  assert_store_miss_invalid_R5: assert property (@(posedge clk) disable iff (rst)
    (state == S_LOOK && tag_we) |-> (op_we && !tag_wd.vld));

  assert_tag_pad_zero_R7: assert property (@(posedge clk) disable iff (rst)
    ctl_done |-> ((ctl_rdata & ~TAG_KEEP) == 32'd0));

  assert_single_done_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cpu_done, ctl_done}));
endmodule

// File: tb/sim_vwt_cache.sv
module sim_vwt_cache;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cache_en = 1'b0;
  logic [2:0]  cur_ctx = '0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic [3:0]  cpu_be = '0;
  logic        pte_wr = 1'b0, pte_sup = 1'b0;
  logic [31:0] cpu_rdata;
  logic        cpu_done;
  logic        ctl_req = 1'b0, ctl_we = 1'b0;
  logic [11:0] ctl_idx = '0;
  logic [31:0] ctl_wdata = '0, ctl_rdata;
  logic        ctl_done;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0]  mem_be;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;

  int n_checks = 0;
  int n_fail = 0;
  int beats = 0;
  logic [31:0] last_wa = '0;

  logic [31:0] phys [logic [31:0]];
  logic [31:0] rmem [logic [31:0]];
  logic [31:0] rtag [int];

  vwt_cache u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] init_word(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                        input logic [3:0] be);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = nw[8*b +: 8];
    return r;
  endfunction

  function automatic logic [31:0] rmem_get(input logic [31:0] a);
    return rmem.exists(a) ? rmem[a] : init_word(a);
  endfunction

  function automatic logic [31:0] rtag_get(input int i);
    return rtag.exists(i) ? rtag[i] : 32'd0;
  endfunction

  // main memory model: one beat answered one cycle after request
  always @(posedge clk) begin
    if (rst) begin
      mem_ack <= 1'b0;
    end else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      beats = beats + 1;
      if (mem_we) begin
        phys[mem_addr] = merge(phys.exists(mem_addr) ? phys[mem_addr] : init_word(mem_addr),
                               mem_wdata, mem_be);
        last_wa = mem_addr;
      end else begin
        mem_rdata <= phys.exists(mem_addr) ? phys[mem_addr] : init_word(mem_addr);
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic ctl_op(input bit we, input int idx, input logic [31:0] wd,
                        output logic [31:0] rd);
    ctl_req = 1'b1; ctl_we = we; ctl_idx = 12'(idx); ctl_wdata = wd;
    do @(negedge clk); while (!ctl_done);
    rd = ctl_rdata;
    ctl_req = 1'b0;
    if (we) rtag[idx] = wd & 32'h01F8_FFFC;
  endtask

  task automatic tag_check(input int idx, input string req);
    logic [31:0] rd;
    ctl_op(1'b0, idx, 32'd0, rd);
    chk(rd == rtag_get(idx), req, "tag word", rd, rtag_get(idx));
  endtask

  task automatic cpu_op(input bit we, input logic [31:0] a, input logic [31:0] wd,
                        input logic [3:0] be, input logic [2:0] cx,
                        input bit pw, input bit ps);
    int idx = int'(a[15:4]);
    logic [13:0] tid = a[29:16];
    logic [31:0] e = rtag_get(idx);
    logic [31:0] wa = {a[31:2], 2'b00};
    logic [31:0] exp_d = rmem_get(wa);
    bit hit;
    int exp_b;
    string req;
    hit = cache_en && e[19] && (e[15:2] == tid) && (e[24:22] == cx);
    exp_b = (!cache_en || we) ? 1 : (hit ? 0 : 4);
    req = !cache_en ? "R6" : (we ? "R3" : (hit ? "R1" : "R2"));
    cur_ctx = cx; pte_wr = pw; pte_sup = ps;
    cpu_we = we; cpu_addr = a; cpu_wdata = wd; cpu_be = be;
    beats = 0;
    cpu_req = 1'b1;
    do @(negedge clk); while (!cpu_done);
    cpu_req = 1'b0;
    chk(beats == exp_b, req, "memory beats", beats, exp_b);
    if (!we) begin
      chk(cpu_rdata == exp_d, "R9", "load data", cpu_rdata, exp_d);
    end else begin
      rmem[wa] = merge(exp_d, wd, be);
      chk(last_wa == wa, "R3", "store address", last_wa, wa);
    end
    if (cache_en && we && !hit) rtag[idx] = e & ~32'h0008_0000;
    if (cache_en && !we && !hit)
      rtag[idx] = {7'd0, cx, pw, ps, 1'b1, 3'd0, tid, 2'd0};
  endtask

  function automatic logic [31:0] mk_addr(input logic [13:0] tid, input int idx,
                                          input int w);
    return {2'b00, tid, 12'(idx), 2'(w), 2'b00};
  endfunction

  initial begin
    #(CLK_PERIOD * 190000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] a;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8: reset state
    chk(!cpu_done && !ctl_done, "R8", "done after reset", {cpu_done, ctl_done}, 0);
    chk(!mem_req, "R8", "mem_req after reset", mem_req, 0);

    // clear every tag before enabling
    for (int i = 0; i < 4096; i++) ctl_op(1'b1, i, 32'd0, rd);

    // R7: pad bits read as zero
    ctl_op(1'b1, 5, 32'hFFFF_FFFF, rd);
    tag_check(5, "R7");
    ctl_op(1'b1, 5, 32'hA5A5_5A5A, rd);
    tag_check(5, "R7");
    ctl_op(1'b1, 5, 32'd0, rd);

    cache_en = 1'b1;
    a = mk_addr(14'd7, 1, 2);
    cpu_op(1'b0, a, 0, 0, 3'd2, 1'b1, 1'b0);                 // R2 refill
    tag_check(1, "R2");
    cpu_op(1'b0, mk_addr(14'd7, 1, 0), 0, 0, 3'd2, 0, 0);    // R1 hit, R9 word 0
    cpu_op(1'b0, mk_addr(14'd7, 1, 3), 0, 0, 3'd2, 0, 0);    // R9 word 3
    cpu_op(1'b0, a, 0, 0, 3'd3, 1'b0, 1'b1);                 // R1 context mismatch
    tag_check(1, "R1");
    cpu_op(1'b1, a, 32'h1122_3344, 4'b0101, 3'd3, 0, 0);     // R4 store hit
    cpu_op(1'b0, a, 0, 0, 3'd3, 0, 0);                       // R4 merged hit
    cpu_op(1'b1, mk_addr(14'h2ABC, 1, 1), 32'hDEAD_BEEF, 4'hF, 3'd3, 0, 0); // R5
    tag_check(1, "R5");
    cpu_op(1'b0, a, 0, 0, 3'd3, 0, 0);                       // R5 miss again
    cpu_op(1'b0, mk_addr(14'h2ABC, 1, 1), 0, 0, 3'd3, 0, 0);

    // R6: bypass leaves tags alone
    cache_en = 1'b0;
    cpu_op(1'b0, mk_addr(14'd9, 1, 0), 0, 0, 3'd3, 0, 0);
    cpu_op(1'b1, mk_addr(14'd9, 1, 0), 32'h0BAD_F00D, 4'b1100, 3'd3, 0, 0);
    tag_check(1, "R6");
    cache_en = 1'b1;
    cpu_op(1'b0, mk_addr(14'd9, 1, 0), 0, 0, 3'd3, 0, 0);

    // constrained random mix over a small address pool
    for (int n = 0; n < 700; n++) begin
      int pick = int'($urandom_range(0, 99));
      int idx = (pick % 4 == 3) ? 9 : (pick % 4) + 1;
      logic [13:0] tid = ($urandom_range(0, 2) == 0) ? 14'd7 :
                         (($urandom_range(0, 1) == 0) ? 14'd8 : 14'h2ABC);
      logic [2:0] cx = ($urandom_range(0, 1) == 0) ? 3'd2 : 3'd3;
      logic [3:0] be = 4'($urandom_range(1, 15));
      a = mk_addr(tid, idx, int'($urandom_range(0, 3)));
      if (pick < 4) cache_en = ~cache_en;
      else if (pick < 12) tag_check(idx, "R7");
      else if (pick < 35) cpu_op(1'b1, a, $urandom, be, cx, 0, 0);
      else cpu_op(1'b0, a, 0, 0, cx, 1'($urandom), 1'($urandom));
    end
    cache_en = 1'b1;
    for (int i = 1; i < 10; i++) tag_check(i, "R7");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule